// File: doc/BRIEF.md
# Indirect Register Access Port for an Ethernet Controller

This block is the host-facing register front end of a bus-mastering Ethernet controller. The host performs 16-bit I/O accesses at four word offsets. One offset holds an index pointer. Two offsets are data windows that read or write the register selected by that pointer. One window serves the control/status bank and the other serves the bus-configuration bank. Reading the fourth offset performs a software reset of the controller's command state.

The control/status bank holds three kinds of register. Index 0 is the command/status word, with stop, start, init and transmit-demand commands and an init-complete flag. Indices 1 and 2 hold the two halves of the init-block bus address. Indices 88 and 89 are read-only identification words. The block asks a DMA engine to fetch the init block by raising `init_req`. It learns that the fetch is complete from `init_done`. It reports the running state on `run` and sends a one-cycle transmit poll on `tx_poll`. The bus-configuration bank holds a parameterised number of plain read/write words, and these words are presented to the rest of the controller on `cfg_regs`.

Read data is combinational: it reflects the current state during the access cycle. Write effects take place at the clock edge that ends the access cycle.

Top module: `csr_window_port`

## Requirements
- R1: After hardware reset, and after any read at offset 0x14, the command word reads 0x0004 (stop flag, bit 2, is the only bit set), and both `init_req` and `run` are low. A read at offset 0x14 itself returns 0. A software reset leaves the index pointer, the address halves and the configuration words unchanged.
- R2: Offset 0x12 reads back the low PTR_W bits of the last value written there. The upper bits read as zero.
- R3: Through offset 0x10, index 88 reads {PART_CODE[3:0], 12'h003} and index 89 reads {ID_REV, PART_CODE[15:4]}. Together they form one 32-bit identity with 0x003 in bits 11:0 and the part code in bits 27:12. Writes to either index are ignored.
- R4: Index 1 holds the low half and index 2 the high half of the init-block address. Both can be read back, and `init_base` equals {index 2, index 1}.
- R5: Writing the command word with bit 0 set, and bit 2 clear, raises `init_req` from the next cycle and clears the stop flag. Bit 0 reads 1 while the request is pending. A repeated init write while a request is pending has no effect.
- R6: A cycle in which `init_req` and `init_done` are both high drops `init_req` and sets the init-complete flag, bit 8. Writing 1 to bit 8 clears the flag; writing 0 there leaves it unchanged. If the flag is set and cleared in the same cycle, the set wins.
- R7: Writing bit 1 to the command word, with bit 2 clear, sets `run` and bit 1 and clears the stop flag. Only the bits written as 1 act, so a write of 0x0002 after init never raises `init_req`.
- R8: Writing bit 2 to the command word sets the stop flag and clears `run` and `init_req`. It takes priority over any init, start or demand bit written in the same word.
- R9: Writing bit 3 to the command word while `run` is high produces exactly one `tx_poll` pulse in the next cycle. The same write while stopped produces none. Bit 3 always reads 0.
- R10: Through offset 0x16, indices below BCR_COUNT are read/write words, and word k appears on `cfg_regs[16k+15:16k]`.
- R11: Control/status indices other than 0, 1, 2, 88 and 89, configuration indices at or above BCR_COUNT, and any other offset read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| io_sel | input | 1 | Host access in this cycle |
| io_wr | input | 1 | 1 = write access, 0 = read access |
| io_addr | input | 5 | Byte offset of the access (0x10, 0x12, 0x14 or 0x16) |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data; zero when no read is taking place |
| init_done | input | 1 | DMA engine has finished fetching the init block |
| init_req | output | 1 | Request to fetch the init block |
| init_base | output | 32 | Bus address of the init block |
| run | output | 1 | Controller started |
| tx_poll | output | 1 | One-cycle transmit demand |
| cfg_regs | output | 16*BCR_COUNT | Configuration words, flattened |

## Verification
A corrupted index pointer shows up on the first read of either data window after it, because the wrong register is returned. A wrong command state shows up on `init_req`, `run` or `tx_poll` one cycle after the write that caused it, and also in the command-word readback. The reference model predicts every output in every cycle, so a divergence is reported in the cycle where it first reaches a port. Write-1-to-clear, stop priority and ignored accesses are each followed by a readback that would show any bit disturbed by them.

// File: rtl/csr_window_port.sv
module csr_window_port #(
  parameter int          PTR_W     = 7,
  parameter int          BCR_COUNT = 8,
  parameter logic [15:0] PART_CODE = 16'h2621,
  parameter logic [3:0]  ID_REV    = 4'h1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_sel,
  input  logic                   io_wr,
  input  logic [4:0]             io_addr,
  input  logic [15:0]            io_wdata,
  output logic [15:0]            io_rdata,
  input  logic                   init_done,
  output logic                   init_req,
  output logic [31:0]            init_base,
  output logic                   run,
  output logic                   tx_poll,
  output logic [16*BCR_COUNT-1:0] cfg_regs
);
  localparam logic [4:0] OFS_DATA = 5'h10;
  localparam logic [4:0] OFS_PTR  = 5'h12;
  localparam logic [4:0] OFS_RST  = 5'h14;
  localparam logic [4:0] OFS_BUS  = 5'h16;
  localparam int BIDX_W = (BCR_COUNT > 1) ? $clog2(BCR_COUNT) : 1;
  localparam logic [PTR_W-1:0] IX_CMD   = PTR_W'(0);
  localparam logic [PTR_W-1:0] IX_BLO   = PTR_W'(1);
  localparam logic [PTR_W-1:0] IX_BHI   = PTR_W'(2);
  localparam logic [PTR_W-1:0] IX_ID_LO = PTR_W'(88);
  localparam logic [PTR_W-1:0] IX_ID_HI = PTR_W'(89);
  localparam logic [PTR_W-1:0] BCR_LIM  = PTR_W'(BCR_COUNT);

  logic [PTR_W-1:0] ptr_q;
  logic             stop_q, run_q, init_q, idon_q, poll_q;
  logic [15:0]      base_lo_q, base_hi_q;
  logic [15:0]      bcr_q [BCR_COUNT];

  logic rd_en, data_wr, ptr_wr, bus_wr, soft_rst, cmd_wr;
  logic stop_cmd, init_cmd, strt_cmd, tdmd_cmd, idon_clr, fetch_end;

  assign rd_en    = io_sel & ~io_wr;
  assign data_wr  = io_sel & io_wr & (io_addr == OFS_DATA);
  assign ptr_wr   = io_sel & io_wr & (io_addr == OFS_PTR);
  assign bus_wr   = io_sel & io_wr & (io_addr == OFS_BUS);
  assign soft_rst = rd_en & (io_addr == OFS_RST);
  assign cmd_wr   = data_wr & (ptr_q == IX_CMD);

  assign stop_cmd  = cmd_wr & io_wdata[2];
  assign init_cmd  = cmd_wr & io_wdata[0] & ~io_wdata[2];
  assign strt_cmd  = cmd_wr & io_wdata[1] & ~io_wdata[2];
  assign tdmd_cmd  = cmd_wr & io_wdata[3] & ~io_wdata[2];
  assign idon_clr  = cmd_wr & io_wdata[8];
  assign fetch_end = init_q & init_done & ~stop_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      run_q  <= 1'b0;
      init_q <= 1'b0;
      idon_q <= 1'b0;
      poll_q <= 1'b0;
    end else if (soft_rst) begin
      stop_q <= 1'b1;
      run_q  <= 1'b0;
      init_q <= 1'b0;
      idon_q <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      stop_q <= stop_cmd ? 1'b1 : ((init_cmd | strt_cmd) ? 1'b0 : stop_q);
      run_q  <= stop_cmd ? 1'b0 : (strt_cmd ? 1'b1 : run_q);
      init_q <= (stop_cmd | fetch_end) ? 1'b0 : (init_cmd ? 1'b1 : init_q);
      idon_q <= fetch_end ? 1'b1 : (idon_clr ? 1'b0 : idon_q);
      poll_q <= tdmd_cmd & run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else begin
      if (ptr_wr) ptr_q <= io_wdata[PTR_W-1:0];
      if (data_wr && ptr_q == IX_BLO) base_lo_q <= io_wdata;
      if (data_wr && ptr_q == IX_BHI) base_hi_q <= io_wdata;
    end
  end

  for (genvar g = 0; g < BCR_COUNT; g++) begin : g_bcr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bcr_q[g] <= '0;
      else if (bus_wr && ptr_q == PTR_W'(g)) bcr_q[g] <= io_wdata;
    end
    assign cfg_regs[16*g +: 16] = bcr_q[g];
  end

  logic [15:0] csr_rd, bcr_rd;

  always_comb begin
    case (ptr_q)
      IX_CMD:   csr_rd = {7'b0, idon_q, 5'b0, stop_q, run_q, init_q};
      IX_BLO:   csr_rd = base_lo_q;
      IX_BHI:   csr_rd = base_hi_q;
      IX_ID_LO: csr_rd = {PART_CODE[3:0], 12'h003};
      IX_ID_HI: csr_rd = {ID_REV, PART_CODE[15:4]};
      default:  csr_rd = '0;
    endcase
  end

  assign bcr_rd = (ptr_q < BCR_LIM) ? bcr_q[ptr_q[BIDX_W-1:0]] : '0;

  always_comb begin
    io_rdata = '0;
    if (rd_en) begin
      case (io_addr)
        OFS_DATA: io_rdata = csr_rd;
        OFS_PTR:  io_rdata = 16'(ptr_q);
        OFS_BUS:  io_rdata = bcr_rd;
        default:  io_rdata = '0;
      endcase
    end
  end

  assign init_req  = init_q;
  assign run       = run_q;
  assign tx_poll   = poll_q;
  assign init_base = {base_hi_q, base_lo_q};
endmodule

// File: rtl/csr_window_port_chk.sv
module csr_window_port_chk #(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_sel,
  input logic             io_wr,
  input logic [4:0]       io_addr,
  input logic [15:0]      io_wdata,
  input logic [15:0]      io_rdata,
  input logic [PTR_W-1:0] ptr_q,
  input logic             init_done,
  input logic             init_req,
  input logic             run,
  input logic             tx_poll
);
  assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && !io_wr && io_addr == 5'h14) |=> (!run && !init_req));

  assert_reset_port_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && !io_wr && io_addr == 5'h14) |-> (io_rdata == 16'h0000));

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && io_wr && io_addr == 5'h12) |=> (ptr_q == $past(io_wdata[PTR_W-1:0])));

  assert_init_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_req) |-> $past(io_sel && io_wr && io_addr == 5'h10 && io_wdata[0]));

  assert_fetch_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_done) |=> !init_req);

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && io_wr && io_addr == 5'h10 && ptr_q == '0 && io_wdata[2]) |=> (!run && !init_req));

  assert_poll_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(run));
endmodule

bind csr_window_port csr_window_port_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .ptr_q(ptr_q), .init_done(init_done),
  .init_req(init_req), .run(run), .tx_poll(tx_poll)
);

// File: tb/test_csr_window_port.sv
module test_csr_window_port;
  localparam int PTR_W = 7;
  localparam int BCR_COUNT = 8;
  localparam logic [15:0] PART = 16'h2621;
  localparam logic [3:0]  REV  = 4'h1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic io_sel = 1'b0, io_wr = 1'b0, init_done = 1'b0;
  logic [4:0] io_addr = '0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic init_req, run, tx_poll;
  logic [31:0] init_base;
  logic [16*BCR_COUNT-1:0] cfg_regs;

  csr_window_port #(.PTR_W(PTR_W), .BCR_COUNT(BCR_COUNT), .PART_CODE(PART), .ID_REV(REV))
    i_csr_window_port (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .init_done(init_done),
      .init_req(init_req), .init_base(init_base), .run(run), .tx_poll(tx_poll),
      .cfg_regs(cfg_regs));

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";
  bit armed = 0;
  bit finished = 0;

  int m_ptr;
  bit m_stop, m_run, m_init, m_idon, m_poll;
  logic [15:0] m_lo, m_hi;
  logic [15:0] m_bcr [BCR_COUNT];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read();
    if (!(io_sel && !io_wr)) return 16'h0;
    case (io_addr)
      5'h10: begin
        if (m_ptr == 0) return 16'(m_idon) << 8 | 16'(m_stop) << 2 | 16'(m_run) << 1 | 16'(m_init);
        if (m_ptr == 1) return m_lo;
        if (m_ptr == 2) return m_hi;
        if (m_ptr == 88) return {PART[3:0], 12'h003};
        if (m_ptr == 89) return {REV, PART[15:4]};
        return 16'h0;
      end
      5'h12: return 16'(m_ptr);
      5'h16: return (m_ptr < BCR_COUNT) ? m_bcr[m_ptr] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_stop = 1; m_run = 0; m_init = 0; m_idon = 0; m_poll = 0;
      m_lo = 0; m_hi = 0;
      for (int k = 0; k < BCR_COUNT; k++) m_bcr[k] = 0;
    end else if (io_sel && !io_wr && io_addr == 5'h14) begin
      m_stop = 1; m_run = 0; m_init = 0; m_idon = 0; m_poll = 0;
    end else begin
      bit w0, done_now;
      w0 = io_sel && io_wr && io_addr == 5'h10 && m_ptr == 0;
      done_now = m_init && init_done && !(w0 && io_wdata[2]);
      m_poll = w0 && io_wdata[3] && !io_wdata[2] && m_run;
      if (done_now) begin m_init = 0; m_idon = 1; end
      else if (w0 && io_wdata[8]) m_idon = 0;
      if (w0) begin
        if (io_wdata[2]) begin m_stop = 1; m_run = 0; m_init = 0; end
        else begin
          if (io_wdata[0] && !m_init && !done_now) begin m_init = 1; m_stop = 0; end
          if (io_wdata[1]) begin m_run = 1; m_stop = 0; end
        end
      end
      if (io_sel && io_wr && io_addr == 5'h10 && m_ptr == 1) m_lo = io_wdata;
      if (io_sel && io_wr && io_addr == 5'h10 && m_ptr == 2) m_hi = io_wdata;
      if (io_sel && io_wr && io_addr == 5'h16 && m_ptr < BCR_COUNT) m_bcr[m_ptr] = io_wdata;
      if (io_sel && io_wr && io_addr == 5'h12) m_ptr = int'(io_wdata) % (1 << PTR_W);
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      check(cur_tag, 32'(io_rdata), 32'(m_read()));
      check(cur_tag, {29'b0, init_req, run, tx_poll}, {29'b0, m_init, m_run, m_poll});
      check("R4", init_base, {m_hi, m_lo});
      for (int k = 0; k < BCR_COUNT; k++)
        check("R10", 32'(cfg_regs[16*k +: 16]), 32'(m_bcr[k]));
    end
  end

  task automatic op(bit s, bit w, logic [4:0] a, logic [15:0] d, bit dn, string tag);
    @(posedge clk); #2;
    io_sel = s; io_wr = w; io_addr = a; io_wdata = d; init_done = dn; cur_tag = tag;
  endtask
  task automatic wr(logic [4:0] a, logic [15:0] d, string tag);
    op(1, 1, a, d, 0, tag);
  endtask
  task automatic idle(string tag);
    op(0, 0, 5'h0, 16'h0, 0, tag);
  endtask
  task automatic rd_exp(logic [4:0] a, logic [15:0] exp, string tag);
    op(1, 0, a, 16'h0, 0, tag);
    @(negedge clk);
    check(tag, 32'(io_rdata), 32'(exp));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1; armed = 1;
    // R1 reset state
    rd_exp(5'h12, 16'h0000, "R1");
    rd_exp(5'h10, 16'h0004, "R1");
    // R2 pointer readback and truncation
    wr(5'h12, 16'd88, "R2");
    rd_exp(5'h12, 16'd88, "R2");
    // R3 identification
    rd_exp(5'h10, 16'h1003, "R3");
    wr(5'h10, 16'hFFFF, "R3");
    rd_exp(5'h10, 16'h1003, "R3");
    wr(5'h12, 16'd89, "R3");
    rd_exp(5'h10, 16'h1262, "R3");
    wr(5'h12, 16'hFF85, "R2");
    rd_exp(5'h12, 16'h0005, "R2");
    // R4 init-block address
    wr(5'h12, 16'd1, "R4"); wr(5'h10, 16'h5678, "R4");
    wr(5'h12, 16'd2, "R4"); wr(5'h10, 16'h1234, "R4");
    idle("R4"); @(negedge clk);
    check("R4", init_base, 32'h1234_5678);
    rd_exp(5'h10, 16'h1234, "R4");
    // R5 init request
    wr(5'h12, 16'd0, "R5");
    wr(5'h10, 16'h0001, "R5");
    idle("R5"); @(negedge clk);
    check("R5", 32'(init_req), 32'd1);
    rd_exp(5'h10, 16'h0001, "R5");
    wr(5'h10, 16'h0001, "R5");
    repeat (3) idle("R5");
    rd_exp(5'h10, 16'h0001, "R5");
    // R6 completion and write-1-to-clear
    op(0, 0, 5'h0, 16'h0, 1, "R6");
    idle("R6"); @(negedge clk);
    check("R6", 32'(init_req), 32'd0);
    rd_exp(5'h10, 16'h0100, "R6");
    wr(5'h10, 16'h0000, "R6");
    rd_exp(5'h10, 16'h0100, "R6");
    wr(5'h10, 16'h0100, "R6");
    rd_exp(5'h10, 16'h0000, "R6");
    // R7 start, no re-init
    wr(5'h10, 16'h0002, "R7");
    idle("R7"); @(negedge clk);
    check("R7", {30'b0, run, init_req}, 32'b10);
    rd_exp(5'h10, 16'h0002, "R7");
    // R9 transmit demand while running
    wr(5'h10, 16'h0008, "R9");
    @(negedge clk); check("R9", 32'(tx_poll), 32'd0);
    idle("R9"); @(negedge clk); check("R9", 32'(tx_poll), 32'd1);
    idle("R9"); @(negedge clk); check("R9", 32'(tx_poll), 32'd0);
    rd_exp(5'h10, 16'h0002, "R9");
    // R8 stop
    wr(5'h10, 16'h0004, "R8");
    rd_exp(5'h10, 16'h0004, "R8");
    wr(5'h10, 16'h0008, "R9");
    idle("R9"); @(negedge clk); check("R9", 32'(tx_poll), 32'd0);
    wr(5'h10, 16'h000F, "R8");
    idle("R8"); @(negedge clk);
    check("R8", {29'b0, init_req, run, tx_poll}, 32'd0);
    rd_exp(5'h10, 16'h0004, "R8");
    wr(5'h10, 16'h0001, "R8");
    wr(5'h10, 16'h0004, "R8");
    idle("R8"); @(negedge clk);
    check("R8", 32'(init_req), 32'd0);
    // R10 configuration words
    wr(5'h12, 16'd3, "R10");
    wr(5'h16, 16'hBEEF, "R10");
    rd_exp(5'h16, 16'hBEEF, "R10");
    check("R10", 32'(cfg_regs[48 +: 16]), 32'h0000_BEEF);
    wr(5'h12, 16'd7, "R10");
    wr(5'h16, 16'h0A5A, "R10");
    rd_exp(5'h16, 16'h0A5A, "R10");
    // R11 unimplemented indices and offsets
    wr(5'h12, 16'd20, "R11");
    wr(5'h16, 16'h1111, "R11");
    rd_exp(5'h16, 16'h0000, "R11");
    wr(5'h12, 16'd50, "R11");
    wr(5'h10, 16'hFFFF, "R11");
    rd_exp(5'h10, 16'h0000, "R11");
    wr(5'h18, 16'hFFFF, "R11");
    rd_exp(5'h18, 16'h0000, "R11");
    wr(5'h12, 16'd0, "R11");
    rd_exp(5'h10, 16'h0004, "R11");
    // R1 software reset with running state and completion flag
    wr(5'h10, 16'h0003, "R1");
    op(0, 0, 5'h0, 16'h0, 1, "R1");
    idle("R1");
    rd_exp(5'h10, 16'h0102, "R1");
    rd_exp(5'h14, 16'h0000, "R1");
    idle("R1"); @(negedge clk);
    check("R1", {30'b0, run, init_req}, 32'd0);
    rd_exp(5'h10, 16'h0004, "R1");
    rd_exp(5'h12, 16'h0000, "R1");
    check("R1", init_base, 32'h1234_5678);
    check("R1", 32'(cfg_regs[48 +: 16]), 32'h0000_BEEF);
    idle("R1"); idle("R1");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule